// File: doc/BRIEF.md
# Variable-Length Prefixed Group Parser

This block sits at the front of a decoder for instruction groups that begin with a 16-bit header halfword. It takes a stream of halfwords and decodes the header. From it, the block computes where each section of the group sits: an optional vector-length block, a set of register-remap entries, a set of predicate-remap entries, and finally the embedded operations. The layout is reported as halfword offsets and entry counts. A decode-error flag is raised when the header is malformed or when its fields describe a group that cannot hold all of its sections.

After the header, every halfword of the group is counted. Halfwords in the two remap regions are unpacked into raw entries, one 16-bit entry or two 8-bit entries per halfword. Each entry carries an unused flag. Narrow predicate entries also get an implicitly assigned register number. When the last halfword of the group has been accepted, a one-cycle end pulse tells downstream logic that the remap entries no longer apply. The block never stalls its input. It does not interpret the contents of the vector-length block, the remap entries or the operations.

Top module: `vliw_prefix_parser`

## Requirements
- R1: A header whose bits 6:0 differ from 7'b1111111 sets `dec_err` when `hdr_valid` pulses.
- R2: Header bits 14:12 (IL) equal to 7 are reserved and set `dec_err`.
- R3: The group is 5+IL halfwords long including the header (`grp_len`). `grp_end` pulses for one cycle in the cycle after the last halfword is accepted, and the halfword accepted next is decoded as a new header.
- R4: Header bit 15 set gives `vl_present`=1 and `vl_off`=1, with the vector-length block taking two halfwords right after the header. When bit 15 is clear, `vl_present`=0 and `vl_off`=0.
- R5: The offsets are computed as follows: `reg_off` = 1 + 2·bit15, `pred_off` = `reg_off` + bits 9:8, `ops_off` = `pred_off` + bits 11:10, and `ops_len` = `grp_len` − `ops_off`. A negative `ops_len` sets `dec_err`.
- R6: Header bit 7 = 1 selects 16-bit entries, and the counts equal bits 9:8 (register) and 11:10 (predicate). Bit 7 = 0 selects 8-bit entries, and each count is doubled (0 to 6).
- R7: One cycle after a halfword in a remap region is accepted, entries appear with `ent_kind` (0 register, 1 predicate) and `ent_wide` set to header bit 7. In 16-bit mode only lane 0 is valid (`ent_vld`=01) and `ent_data[15:0]` is the halfword. In 8-bit mode both lanes are valid: lane 0 carries bits 7:0 in `ent_data[7:0]` and lane 1 carries bits 15:8 in `ent_data[23:16]`, with the other data bits zero. Halfwords of the header, the vector-length block and the operations produce `ent_vld`=00.
- R8: An 8-bit entry of value 0x00 has its `ent_unused` lane bit set. 16-bit entries are never marked unused.
- R9: The 8-bit predicate entry with index k (counted from 0 across the predicate region, lane 0 before lane 1) gets register number 9+k. Lane 0 reports it in `ent_preg[4:0]` and lane 1 in `ent_preg[9:5]`. All other entries report 0.
- R10: A header with `dec_err` produces no entries and no `grp_end`, and the next accepted halfword is treated as a header.
- R11: `in_ready` is always high. A cycle with `in_valid` low advances nothing and produces no `hdr_valid`, entries or `grp_end` in the following cycle.
- R12: `grp_end` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input halfword valid |
| in_ready | output | 1 | Always high |
| in_hw | input | 16 | Input halfword |
| hdr_valid | output | 1 | Pulse: layout outputs updated from a new header |
| dec_err | output | 1 | Last header was malformed |
| vl_present | output | 1 | Vector-length block present |
| vl_off | output | 4 | Halfword offset of vector-length block (0 if absent) |
| reg_off | output | 4 | Halfword offset of register-remap entries |
| reg_cnt | output | 3 | Number of register-remap entries |
| pred_off | output | 4 | Halfword offset of predicate-remap entries |
| pred_cnt | output | 3 | Number of predicate-remap entries |
| ops_off | output | 4 | Halfword offset of embedded operations |
| ops_len | output | 4 | Halfword length of embedded operations |
| grp_len | output | 4 | Total group length in halfwords |
| ent_vld | output | 2 | Per-lane entry valid |
| ent_kind | output | 1 | 0 register entry, 1 predicate entry |
| ent_wide | output | 1 | Entries are 16-bit |
| ent_data | output | 32 | Raw entries, lane 0 in bits 15:0, lane 1 in bits 31:16 |
| ent_unused | output | 2 | Per-lane unused marker |
| ent_preg | output | 10 | Implicit predicate register numbers, 5 bits per lane |
| grp_end | output | 1 | Pulse: group finished, remap entries cease to apply |

## Verification
Fixed headers cover several layouts. A wide group with a vector-length block and both entry kinds separates the 16-bit path from the 8-bit one. A narrow group with zero bytes exercises unused marking. A narrow predicate-only group with three count steps checks implicit numbering up to x14. A header with no entries isolates the operations length. Malformed signatures, the reserved IL value and an overfull header that leaves a negative operations length each exercise one error source. Back-to-back groups, idle gaps and a stream of pseudo-random headers and payloads then check that group boundaries and region classification stay aligned with a behavioural model on every cycle.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
   // halfword offset / length width
   localparam int LW        = 4;
   // entry count width (0..6)
   localparam int CW        = 3;
   localparam logic [6:0] HDR_SIG = 7'h7F;
   // fixed part of group length in halfwords (80 bits)
   localparam int BASE_HW   = 5;
   // vector-length block length in halfwords
   localparam int VLB_HW    = 2;
   localparam int LANES     = 2;

   typedef struct packed {
      logic          err;
      logic          vlp;
      logic          wide;
      logic [LW-1:0] vl_off;
      logic [LW-1:0] reg_off;
      logic [LW-1:0] pred_off;
      logic [LW-1:0] ops_off;
      logic [LW-1:0] ops_len;
      logic [LW-1:0] grp_len;
      logic [CW-1:0] reg_cnt;
      logic [CW-1:0] pred_cnt;
   } layout_t;
endpackage

// File: rtl/vlp_hdr_decode.sv
module vlp_hdr_decode
   import vlp_pkg::*;
(
   input  logic [15:0] hw,
   output layout_t     lay
);
   localparam int XW = LW + 1;

   logic [2:0]    il;
   logic [1:0]    rfld, pfld;
   logic [XW-1:0] tot, roff, poff, ooff, diff;
   logic          sig_bad, il_bad, neg;

   always_comb begin
      il      = hw[14:12];
      rfld    = hw[9:8];
      pfld    = hw[11:10];
      tot     = XW'(BASE_HW) + XW'(il);
      roff    = XW'(1) + (hw[15] ? XW'(VLB_HW) : XW'(0));
      poff    = roff + XW'(rfld);
      ooff    = poff + XW'(pfld);
      diff    = tot - ooff;
      neg     = ooff > tot;
      sig_bad = hw[6:0] != HDR_SIG;
      il_bad  = il == 3'd7;

      lay.err      = sig_bad | il_bad | neg;
      lay.vlp      = hw[15];
      lay.wide     = hw[7];
      lay.vl_off   = hw[15] ? LW'(1) : LW'(0);
      lay.reg_off  = roff[LW-1:0];
      lay.pred_off = poff[LW-1:0];
      lay.ops_off  = ooff[LW-1:0];
      lay.ops_len  = diff[LW-1:0];
      lay.grp_len  = tot[LW-1:0];
      lay.reg_cnt  = hw[7] ? CW'(rfld) : CW'({rfld, 1'b0});
      lay.pred_cnt = hw[7] ? CW'(pfld) : CW'({pfld, 1'b0});
   end
endmodule

// File: rtl/vlp_entry_unpack.sv
module vlp_entry_unpack
   import vlp_pkg::*;
#(
   parameter int PRED_BASE = 9,
   parameter int PREG_W    = 5
)(
   input  logic [15:0]             hw,
   input  logic                    wide,
   input  logic                    is_pred,
   input  logic [LW-1:0]           k_hw,
   output logic [LANES-1:0]        vld,
   output logic [16*LANES-1:0]     data,
   output logic [LANES-1:0]        unused,
   output logic [PREG_W*LANES-1:0] preg
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] byt;
      logic [PREG_W-1:0] num;
      assign byt = hw[8*l +: 8];
      assign num = PREG_W'(PRED_BASE + l) + PREG_W'({k_hw, 1'b0});
      if (l == 0) begin : g_first
         assign vld[l]          = 1'b1;
         assign data[16*l +: 16] = wide ? hw : {8'h00, byt};
      end else begin : g_other
         assign vld[l]          = ~wide;
         assign data[16*l +: 16] = wide ? 16'h0000 : {8'h00, byt};
      end
      assign unused[l]             = ~wide & (byt == 8'h00);
      assign preg[PREG_W*l +: PREG_W] = (~wide & is_pred) ? num : '0;
   end
endmodule

// File: rtl/vliw_prefix_parser.sv
module vliw_prefix_parser
   import vlp_pkg::*;
#(
   parameter int PRED_BASE = 9,
   parameter int PREG_W    = 5
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [15:0]             in_hw,
   output logic                    hdr_valid,
   output logic                    dec_err,
   output logic                    vl_present,
   output logic [LW-1:0]           vl_off,
   output logic [LW-1:0]           reg_off,
   output logic [CW-1:0]           reg_cnt,
   output logic [LW-1:0]           pred_off,
   output logic [CW-1:0]           pred_cnt,
   output logic [LW-1:0]           ops_off,
   output logic [LW-1:0]           ops_len,
   output logic [LW-1:0]           grp_len,
   output logic [LANES-1:0]        ent_vld,
   output logic                    ent_kind,
   output logic                    ent_wide,
   output logic [16*LANES-1:0]     ent_data,
   output logic [LANES-1:0]        ent_unused,
   output logic [PREG_W*LANES-1:0] ent_preg,
   output logic                    grp_end
);
   // highest implicit register (6 narrow entries) must fit the field
   initial assert (PRED_BASE + 2*3*2 <= (1 << PREG_W))
      else $error("PREG_W too narrow for PRED_BASE");

   layout_t       dec, lay_q;
   logic          busy;
   logic [LW-1:0] pos, k_hw, last_pos;
   logic          hdr_acc, body_acc, in_ent, is_pred, last;
   logic [LANES-1:0]        u_vld, u_unused;
   logic [16*LANES-1:0]     u_data;
   logic [PREG_W*LANES-1:0] u_preg;

   vlp_hdr_decode u_dec (.hw(in_hw), .lay(dec));

   assign in_ready = 1'b1;
   assign hdr_acc  = in_valid & ~busy;
   assign body_acc = in_valid & busy;
   assign in_ent   = (pos >= lay_q.reg_off) && (pos < lay_q.ops_off);
   assign is_pred  = pos >= lay_q.pred_off;
   assign k_hw     = pos - lay_q.pred_off;
   assign last_pos = lay_q.grp_len - LW'(1);
   assign last     = pos == last_pos;

   vlp_entry_unpack #(.PRED_BASE(PRED_BASE), .PREG_W(PREG_W)) u_unp (
      .hw(in_hw), .wide(lay_q.wide), .is_pred(is_pred), .k_hw(k_hw),
      .vld(u_vld), .data(u_data), .unused(u_unused), .preg(u_preg)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         pos        <= '0;
         lay_q      <= '0;
         hdr_valid  <= 1'b0;
         grp_end    <= 1'b0;
         ent_vld    <= '0;
         ent_kind   <= 1'b0;
         ent_wide   <= 1'b0;
         ent_data   <= '0;
         ent_unused <= '0;
         ent_preg   <= '0;
      end else begin
         hdr_valid <= hdr_acc;
         grp_end   <= body_acc & last;
         ent_vld   <= (body_acc & in_ent) ? u_vld : '0;
         if (body_acc & in_ent) begin
            ent_kind   <= is_pred;
            ent_wide   <= lay_q.wide;
            ent_data   <= u_data;
            ent_unused <= u_unused;
            ent_preg   <= u_preg;
         end
         if (hdr_acc) begin
            lay_q <= dec;
            if (!dec.err) begin
               busy <= 1'b1;
               pos  <= LW'(1);
            end
         end else if (body_acc) begin
            if (last) busy <= 1'b0;
            else      pos  <= pos + LW'(1);
         end
      end
   end

   assign dec_err    = lay_q.err;
   assign vl_present = lay_q.vlp;
   assign vl_off     = lay_q.vl_off;
   assign reg_off    = lay_q.reg_off;
   assign reg_cnt    = lay_q.reg_cnt;
   assign pred_off   = lay_q.pred_off;
   assign pred_cnt   = lay_q.pred_cnt;
   assign ops_off    = lay_q.ops_off;
   assign ops_len    = lay_q.ops_len;
   assign grp_len    = lay_q.grp_len;

   assert_grp_end_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      grp_end |=> !grp_end);
   assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && dec_err) |=> (!grp_end && ent_vld == '0));
   assert_layout_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && !dec_err) |-> (ops_off + ops_len == grp_len));
   assert_grp_len_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |-> (grp_len >= LW'(BASE_HW)));
   assert_narrow_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ent_vld[1] |-> (!ent_wide && ent_vld[0]));
   assert_unused_narrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_unused != '0 && ent_vld != '0) |-> !ent_wide);
   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!hdr_valid && !grp_end && ent_vld == '0));
endmodule

// File: tb/vliw_prefix_parser_tb.sv
module vliw_prefix_parser_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_hw = 16'h0;
   logic        in_ready, hdr_valid, dec_err, vl_present, ent_kind, ent_wide, grp_end;
   logic [3:0]  vl_off, reg_off, pred_off, ops_off, ops_len, grp_len;
   logic [2:0]  reg_cnt, pred_cnt;
   logic [1:0]  ent_vld, ent_unused;
   logic [31:0] ent_data;
   logic [9:0]  ent_preg;

   always #2 clk = ~clk;   // 250 MHz

   vliw_prefix_parser u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_hw(in_hw),
      .hdr_valid(hdr_valid), .dec_err(dec_err), .vl_present(vl_present), .vl_off(vl_off),
      .reg_off(reg_off), .reg_cnt(reg_cnt), .pred_off(pred_off), .pred_cnt(pred_cnt),
      .ops_off(ops_off), .ops_len(ops_len), .grp_len(grp_len), .ent_vld(ent_vld),
      .ent_kind(ent_kind), .ent_wide(ent_wide), .ent_data(ent_data),
      .ent_unused(ent_unused), .ent_preg(ent_preg), .grp_end(grp_end)
   );

   int vectors = 0, fails = 0, cycles = 0;
   bit finished = 0;

   // behavioural reference state
   bit m_busy; int m_pos, m_tot, m_roff, m_poff, m_ooff; bit m_wide;
   bit e_hdr, e_err, e_vlp, e_end, e_kind, e_wide;
   int e_vloff, e_roff, e_rcnt, e_poff, e_pcnt, e_ooff, e_olen, e_tot;
   int e_vld, e_data, e_unused, e_preg;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_pos = 0; m_tot = 0; m_roff = 0; m_poff = 0; m_ooff = 0; m_wide = 0;
         e_hdr = 0; e_err = 0; e_end = 0; e_vld = 0;
      end else begin
         e_hdr = 0; e_end = 0; e_vld = 0;
         if (in_valid) begin
            if (!m_busy) begin
               int il, r, p, olen; bit vl, w, bad;
               il = in_hw[14:12]; vl = in_hw[15]; w = in_hw[7];
               r = in_hw[9:8]; p = in_hw[11:10];
               e_tot = 5 + il; e_roff = 1 + (vl ? 2 : 0);
               e_poff = e_roff + r; e_ooff = e_poff + p; olen = e_tot - e_ooff;
               bad = (in_hw[6:0] != 7'h7F) || (il == 7) || (olen < 0);
               e_hdr = 1; e_err = bad; e_vlp = vl; e_vloff = vl ? 1 : 0;
               e_rcnt = w ? r : 2*r; e_pcnt = w ? p : 2*p; e_olen = olen;
               if (!bad) begin
                  m_busy = 1; m_pos = 1; m_tot = e_tot; m_roff = e_roff;
                  m_poff = e_poff; m_ooff = e_ooff; m_wide = w;
               end
            end else begin
               if (m_pos >= m_roff && m_pos < m_ooff) begin
                  e_kind = (m_pos >= m_poff); e_wide = m_wide;
                  if (m_wide) begin
                     e_vld = 1; e_data = {16'h0, in_hw}; e_unused = 0; e_preg = 0;
                  end else begin
                     int k;
                     k = 2 * (m_pos - m_poff);
                     e_vld = 3;
                     e_data = {8'h0, in_hw[15:8], 8'h0, in_hw[7:0]};
                     e_unused = {30'h0, in_hw[15:8] == 8'h0, in_hw[7:0] == 8'h0};
                     e_preg = e_kind ? (((9 + k + 1) << 5) | (9 + k)) : 0;
                  end
               end
               if (m_pos == m_tot - 1) begin m_busy = 0; e_end = 1; end
               else m_pos = m_pos + 1;
            end
         end
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (rst_n && !finished) begin
         chk("R11", "in_ready", in_ready, 1);
         chk("R11", "hdr_valid", hdr_valid, e_hdr);
         chk("R1", "dec_err", dec_err, e_err);
         chk("R3", "grp_end", grp_end, e_end);
         chk("R7", "ent_vld", ent_vld, e_vld);
         if (!e_err) begin
            chk("R4", "vl_present", vl_present, e_vlp);
            chk("R4", "vl_off", vl_off, e_vloff);
            chk("R5", "reg_off", reg_off, e_roff);
            chk("R5", "pred_off", pred_off, e_poff);
            chk("R5", "ops_off", ops_off, e_ooff);
            chk("R5", "ops_len", ops_len, e_olen);
            chk("R3", "grp_len", grp_len, e_tot);
            chk("R6", "reg_cnt", reg_cnt, e_rcnt);
            chk("R6", "pred_cnt", pred_cnt, e_pcnt);
         end
         if (e_vld != 0) begin
            chk("R7", "ent_kind", ent_kind, e_kind);
            chk("R7", "ent_wide", ent_wide, e_wide);
            chk("R7", "ent_data", ent_data, e_data);
            chk("R8", "ent_unused", ent_unused, e_unused);
            chk("R9", "ent_preg", ent_preg, e_preg);
         end
      end
      if (cycles > 60000 && !finished) begin
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic send(logic [15:0] v);
      @(negedge clk); in_valid = 1'b1; in_hw = v;
      @(posedge clk); #1 in_valid = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(posedge clk);
   endtask

   function automatic int hw_count(logic [15:0] h);
      int tot, ooff;
      tot = 5 + h[14:12];
      ooff = 1 + (h[15] ? 2 : 0) + h[9:8] + h[11:10];
      if (h[6:0] != 7'h7F || h[14:12] == 3'd7 || ooff > tot) return 1;
      return tot;
   endfunction

   // header followed by its body; payload from seed, gaps if requested
   task automatic group(logic [15:0] h, int seed, bit gaps);
      int n;
      n = hw_count(h);
      send(h);
      for (int i = 1; i < n; i++) begin
         if (gaps && ($urandom % 3 == 0)) idle(1 + $urandom % 2);
         send(16'((seed * 37 + i * 4099) ^ ((i % 2) ? 16'h00FF : 16'h0)));
      end
   endtask

   initial begin
      idle(3);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      // reset state (R3, R10, R11)
      chk("R10", "dec_err after reset", dec_err, 0);
      chk("R3", "grp_end after reset", grp_end, 0);
      chk("R11", "hdr_valid after reset", hdr_valid, 0);
      // R4 R6 R7: wide, VL block, 2 reg + 1 pred, IL=3
      group(16'hB6FF, 1, 0);
      idle(2);
      // R6 R8: narrow, 3 reg halfwords, 2 pred halfwords, zero bytes
      send(16'h2B7F);
      send(16'h0000); send(16'h1200); send(16'h0034);
      send(16'h0A00); send(16'h0000); send(16'hBEEF);
      // R9: narrow predicate-only, 3 halfwords -> x9..x14, back to back
      group(16'h6C7F, 2, 0);
      // R1 signature, R2 reserved IL, R5 overfull -> R10 next is header
      send(16'h007E);
      send(16'h707F);
      send(16'h8F7F);
      // R5: no entries, ops length 4; wide variant too
      group(16'h007F, 3, 0);
      group(16'h00FF, 4, 1);
      // R11: gaps inside groups
      group(16'hA5FF, 5, 1);
      group(16'hD27F, 6, 1);
      // mixed pseudo-random headers and payloads
      for (int g = 0; g < 300; g++) begin
         logic [15:0] h;
         h = 16'($urandom);
         if ($urandom % 8 != 0) h[6:0] = 7'h7F;
         if ($urandom % 2 == 0) idle($urandom % 3);
         group(h, g + 7, ($urandom % 2) == 1);
      end
      idle(4);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule